// File: doc/BRIEF.md
# Host Access and Status Controller

This block connects a CPU's uncached load/store port and register port to a serial link engine. CPU word reads and writes to a 2 KB window become single-word link requests. Register writes can start a 64-byte block read or a 64-byte block write over the same link. The link engine does the bit-level work. The controller decides which operation goes next, holds the CPU when it must wait, and keeps a 32-bit status word. That word holds busy, read-pending, error and interrupt flags and the encodings of its two internal state machines.

Writes are posted: a window write is accepted at once when the link is free, and the CPU carries on while it completes. Reads block: the CPU is stalled until the link returns the word. A read that arrives while a write is on the link waits and is issued after that write finishes. A direct word write counts as busy and raises the completion interrupt, the same as a block transfer. The error flag is sticky and only reset clears it.

Top module: `hostlink_ctl`

## Requirements
- R1: After reset the status word is zero, `irq` is low, `lk_req` is low and `win_stall` is low while no strobe is active.
- R2: With the link idle and nothing queued, a window write is accepted without stall. In the next cycle `lk_req` is high, `lk_kind` is 2'b10, `lk_addr` equals window offset bits [10:2] and `lk_wdata` carries the written word.
- R3: While a direct word write is on the link, status bit 0 (busy) and bit 1 (word-write busy) are set and the link-state field, bits 7:4, reads 2. Both busy bits clear after `lk_done`.
- R4: A window read issues `lk_kind` 2'b11 and stalls the CPU until the link returns data. With L cycles between request and `lk_done`, the CPU sees exactly L+2 stalled cycles from an idle start. `win_rdata` holds the returned word in the first cycle without stall, and status bit 2 (read pending) is set while the read waits.
- R5: A read presented while a word write is on the link is held. Its link request appears only after the write completes.
- R6: A register write with selector 1 queues a block read (`lk_kind` 2'b01), and selector 2 queues a block write (`lk_kind` 2'b00). The request address is `reg_wdata` bits [10:2]. While the block transfer is queued or running, bit 0 is set and bit 1 is clear. The DMA-state field, bits 11:8, reads 1 when queued and 2 when running.
- R7: The interrupt flag, which drives `irq` and status bit 12, sets when a block transfer or a direct word write completes. It does not set when a word read completes.
- R8: A register write with selector 0 clears the interrupt flag, whatever the data value.
- R9: A block trigger that arrives while status bit 0 is set sets status bit 3 (error) and is dropped: no extra link request follows.
- R10: A window write whose offset bits [1:0] are nonzero sets the error bit and is still issued at word address [10:2]. A block trigger with nonzero bits [1:0] sets the error bit and is dropped.
- R11: The error bit stays set through later traffic and interrupt clears until reset.
- R12: Status bits 31:13 always read zero.
- R13: A window write that arrives while the link is busy stalls until the link is free. With L cycles of link latency on the earlier write, the stall lasts L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_addr | input | AW | Byte offset inside the window |
| win_wdata | input | DW | Window write data |
| win_rd | input | 1 | Window read strobe, held until not stalled |
| win_wr | input | 1 | Window write strobe, held until not stalled |
| win_rdata | output | DW | Returned read word |
| win_stall | output | 1 | CPU must hold its strobe |
| reg_sel | input | 2 | 0 status, 1 block read trigger, 2 block write trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | AW | Block trigger offset (ignored for status) |
| stat_word | output | 32 | Status word |
| lk_req | output | 1 | Link request, held until done |
| lk_kind | output | 2 | 11 word read, 10 word write, 01 block read, 00 block write |
| lk_addr | output | AW-2 | Word address of the request |
| lk_wdata | output | DW | Word write data |
| lk_done | input | 1 | Link completion pulse |
| lk_rdata | input | DW | Word read result, valid with `lk_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench issues a read directly behind a posted write. A design that does not defer the read would put a read request on the link while the write is still there, and the recorded request order would come out wrong. Stall lengths are checked as a count of cycles against the link latency: an extra register stage, or data released early, shows up as an off-by-one count. Each block trigger is checked against the busy state it lands in. A design that queues a trigger instead of dropping it would emit an extra request. A design that clears the error on an interrupt clear, or forgets that a direct write counts as busy, would show the wrong status word. A sweep over every word address confirms that the address bits map onto the link request correctly and that read data comes back to the CPU.

// File: rtl/hostlink_ctl.sv
`timescale 1ns/1ps
module hostlink_ctl #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] win_addr,
  input  logic [DW-1:0] win_wdata,
  input  logic          win_rd,
  input  logic          win_wr,
  output logic [DW-1:0] win_rdata,
  output logic          win_stall,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_wdata,
  output logic [31:0]   stat_word,
  output logic          lk_req,
  output logic [1:0]    lk_kind,
  output logic [AW-3:0] lk_addr,
  output logic [DW-1:0] lk_wdata,
  input  logic          lk_done,
  input  logic [DW-1:0] lk_rdata,
  output logic          irq
);
  localparam int WAW = AW - 2;

  typedef enum logic [3:0] {LK_IDLE = 4'd0, LK_RDW = 4'd1, LK_WRW = 4'd2,
                            LK_RDB = 4'd3, LK_WRB = 4'd4} lk_e;
  typedef enum logic [3:0] {DM_IDLE = 4'd0, DM_QUEUE = 4'd1, DM_RUN = 4'd2} dm_e;
  typedef enum logic [1:0] {RD_NONE, RD_WAIT, RD_FLY, RD_DONE} rd_e;

  lk_e            lk_q;
  dm_e            dm_q;
  rd_e            rd_q;
  logic           dm_dir_q;
  logic [WAW-1:0] dm_addr_q, rd_addr_q, req_addr_q;
  logic [DW-1:0]  req_wdata_q, rbuf_q;
  logic           irq_q, err_q;

  wire link_idle = (lk_q == LK_IDLE);
  wire rd_take   = win_rd && (rd_q == RD_NONE);
  wire start_rd  = link_idle && ((rd_q == RD_WAIT) || rd_take);
  wire start_dm  = link_idle && !start_rd && (dm_q == DM_QUEUE);
  wire wr_go     = win_wr && !win_rd && link_idle && (rd_q == RD_NONE) && (dm_q != DM_QUEUE);
  wire io_busy   = (lk_q == LK_WRW);
  wire dm_busy   = (dm_q != DM_IDLE) || io_busy;
  wire trig      = reg_wr && ((reg_sel == 2'd1) || (reg_sel == 2'd2));
  wire trig_bad  = trig && (dm_busy || (reg_wdata[1:0] != 2'b00));
  wire trig_ok   = trig && !trig_bad;
  wire fin       = lk_done && !link_idle;
  wire [WAW-1:0] rd_word = (rd_q == RD_WAIT) ? rd_addr_q : win_addr[AW-1:2];

  assign win_stall = (win_rd && (rd_q != RD_DONE)) || (win_wr && !win_rd && !wr_go);
  assign win_rdata = rbuf_q;
  assign lk_req    = !link_idle;
  assign lk_addr   = req_addr_q;
  assign lk_wdata  = req_wdata_q;
  assign irq       = irq_q;
  assign stat_word = {19'd0, irq_q, dm_q, lk_q, err_q, (rd_q != RD_NONE), io_busy, dm_busy};

  always_comb begin
    case (lk_q)
      LK_RDW:  lk_kind = 2'b11;
      LK_WRW:  lk_kind = 2'b10;
      LK_RDB:  lk_kind = 2'b01;
      default: lk_kind = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_q        <= LK_IDLE;
      dm_q        <= DM_IDLE;
      rd_q        <= RD_NONE;
      dm_dir_q    <= 1'b0;
      dm_addr_q   <= '0;
      rd_addr_q   <= '0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rbuf_q      <= '0;
      irq_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (fin) lk_q <= LK_IDLE;

      if (start_rd) begin
        lk_q       <= LK_RDW;
        req_addr_q <= rd_word;
      end else if (start_dm) begin
        lk_q       <= dm_dir_q ? LK_WRB : LK_RDB;
        req_addr_q <= dm_addr_q;
        dm_q       <= DM_RUN;
      end else if (wr_go) begin
        lk_q        <= LK_WRW;
        req_addr_q  <= win_addr[AW-1:2];
        req_wdata_q <= win_wdata;
      end

      case (rd_q)
        RD_NONE: if (win_rd) begin
          rd_addr_q <= win_addr[AW-1:2];
          rd_q      <= start_rd ? RD_FLY : RD_WAIT;
        end
        RD_WAIT: if (start_rd) rd_q <= RD_FLY;
        RD_FLY:  if (fin) begin
          rd_q   <= RD_DONE;
          rbuf_q <= lk_rdata;
        end
        default: if (win_rd) rd_q <= RD_NONE;
      endcase

      if (trig_ok) begin
        dm_q      <= DM_QUEUE;
        dm_dir_q  <= (reg_sel == 2'd2);
        dm_addr_q <= reg_wdata[AW-1:2];
      end
      if (fin && ((lk_q == LK_RDB) || (lk_q == LK_WRB))) dm_q <= DM_IDLE;

      if (fin && (lk_q != LK_RDW)) irq_q <= 1'b1;
      else if (reg_wr && (reg_sel == 2'd0)) irq_q <= 1'b0;

      if (trig_bad || (wr_go && (win_addr[1:0] != 2'b00))) err_q <= 1'b1;
    end
  end
endmodule

module hostlink_ctl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_rd,
  input logic          win_wr,
  input logic          win_stall,
  input logic          lk_req,
  input logic          lk_done,
  input logic [1:0]    lk_kind,
  input logic [AW-3:0] lk_addr,
  input logic [31:0]   stat_word,
  input logic          irq
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_done |=> lk_req && $stable(lk_kind) && $stable(lk_addr));

  p_wr_nostall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && !win_rd && !lk_req && !stat_word[0] && !stat_word[2] |-> !win_stall);

  p_io_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[1] |-> stat_word[0]);

  p_rd_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && win_stall |=> stat_word[2]);

  p_irq_on_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && lk_done && (lk_kind != 2'b11) |=> irq);

  p_no_irq_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && lk_done && (lk_kind == 2'b11) && !irq |=> !irq);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[3] |=> stat_word[3]);
endmodule

bind hostlink_ctl hostlink_ctl_chk #(.AW(AW)) chk_i (.*);

// File: tb/hostlink_ctl_tb_top.sv
`timescale 1ns/1ps
module hostlink_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] win_addr = '0;
  logic [31:0] win_wdata = '0;
  logic        win_rd = 1'b0, win_wr = 1'b0;
  logic [31:0] win_rdata;
  logic        win_stall;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [10:0] reg_wdata = '0;
  logic [31:0] stat_word;
  logic        lk_req;
  logic [1:0]  lk_kind;
  logic [8:0]  lk_addr;
  logic [31:0] lk_wdata;
  logic        lk_done = 1'b0;
  logic [31:0] lk_rdata = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  hostlink_ctl dut_i (.*);

  int nchk = 0, nerr = 0, cyc = 0;
  int lat = 2, nreq = 0;
  logic [1:0]  klog [0:63];
  logic [1:0]  last_kind;
  logic [8:0]  last_addr;
  logic [31:0] last_wdata;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] fmod(input logic [8:0] a);
    return 32'hA500_0000 ^ ({23'd0, a} * 32'h0001_0003);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (lk_req && rst_n) begin
        last_kind  = lk_kind;
        last_addr  = lk_addr;
        last_wdata = lk_wdata;
        klog[nreq % 64] = lk_kind;
        nreq++;
        repeat (lat) @(negedge clk);
        lk_done  = 1'b1;
        lk_rdata = fmod(lk_addr);
        @(negedge clk);
        lk_done  = 1'b0;
      end
    end
  end

  task automatic win_write(input logic [10:0] a, input logic [31:0] d, output int ns);
    ns = 0;
    @(negedge clk);
    win_wr = 1'b1; win_addr = a; win_wdata = d;
    #1;
    while (win_stall) begin ns++; @(negedge clk); #1; end
    @(negedge clk);
    win_wr = 1'b0;
    #1;
  endtask

  task automatic win_read(input logic [10:0] a, output logic [31:0] d, output int ns,
                          output bit pend, output logic [1:0] kind0);
    ns = 0; pend = 0;
    @(negedge clk);
    win_rd = 1'b1; win_addr = a;
    #1;
    kind0 = lk_req ? lk_kind : 2'bxx;
    while (win_stall) begin
      ns++;
      if (stat_word[2]) pend = 1;
      @(negedge clk); #1;
    end
    d = win_rdata;
    @(negedge clk);
    win_rd = 1'b0;
    #1;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [10:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (lk_req || stat_word[0] || stat_word[2]) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    wait (cyc > 150000);
    nerr++;
    $display("FAIL watchdog act=%0d cycles exp=completion", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int ns, n0;
    bit pend;
    logic [31:0] d;
    logic [1:0] k0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stat_word == 32'd0, "R1 status after reset", stat_word, 0);
    chk(!irq && !lk_req && !win_stall, "R1 outputs after reset", {irq, lk_req, win_stall}, 0);

    // R2 / R3: posted write
    lat = 3;
    win_write(11'h010, 32'hDEAD_BEEF, ns);
    chk(ns == 0, "R2 write no stall", ns, 0);
    chk(lk_req && lk_kind == 2'b10, "R2 write kind", {lk_req, lk_kind}, 3'b110);
    chk(lk_addr == 9'd4 && lk_wdata == 32'hDEAD_BEEF, "R2 write addr/data", lk_wdata, 32'hDEAD_BEEF);
    chk(stat_word[1:0] == 2'b11 && stat_word[7:4] == 4'd2, "R3 busy during write", stat_word, 32'h23);
    wait_idle();
    chk(stat_word[1:0] == 2'b00, "R3 busy cleared", stat_word[1:0], 0);
    chk(irq && stat_word[12], "R7 irq after word write", irq, 1);
    chk(stat_word[31:13] == 0, "R12 upper zero", stat_word, 32'h1000);
    reg_write(2'd0, 11'h5A5);
    chk(!irq && !stat_word[12], "R8 status write clears irq", irq, 0);

    // R4: read stall length over latencies, no interrupt
    for (int L = 0; L < 6; L++) begin
      lat = L;
      win_read(11'h100 + 11'(L * 4), d, ns, pend, k0);
      chk(ns == L + 2, "R4 read stall length", ns, L + 2);
      chk(d == fmod(9'h40 + 9'(L)), "R4 read data", d, fmod(9'h40 + 9'(L)));
      chk(pend, "R4 pending bit during read", pend, 1);
      chk(last_kind == 2'b11, "R4 read kind", last_kind, 2'b11);
      wait_idle();
      chk(!irq, "R7 no irq on read", irq, 0);
    end

    // R13: write behind write stalls for link latency
    lat = 6;
    win_write(11'h020, 32'h1111_1111, ns);
    win_write(11'h024, 32'h2222_2222, ns);
    chk(ns == 6, "R13 write stall length", ns, 6);
    chk(lk_req && lk_kind == 2'b10 && lk_addr == 9'd9, "R13 second write issued", lk_addr, 9);
    wait_idle();

    // R5: read deferred behind write
    lat = 4;
    win_write(11'h040, 32'h3333_3333, ns);
    n0 = nreq;
    win_read(11'h044, d, ns, pend, k0);
    chk(k0 == 2'b10, "R5 write on link at read start", k0, 2'b10);
    chk(nreq == n0 + 1 && klog[(n0 - 1) % 64] == 2'b10 && klog[n0 % 64] == 2'b11,
        "R5 read ordered after write", nreq, n0 + 1);
    chk(d == fmod(9'h11), "R5 deferred read data", d, fmod(9'h11));
    wait_idle();
    reg_write(2'd0, 11'h0);

    // R6 / R9: block read, retrigger while busy dropped
    lat = 3;
    n0 = nreq;
    reg_write(2'd1, 11'h7C0);
    chk(stat_word[11:8] == 4'd1 && stat_word[1:0] == 2'b01, "R6 block queued", stat_word, 32'h101);
    @(negedge clk); #1;
    chk(stat_word[11:8] == 4'd2 && lk_req && lk_kind == 2'b01 && lk_addr == 9'h1F0,
        "R6 block read running", {stat_word[11:8], 2'b0, lk_kind, 3'b0, lk_addr}, {4'd2, 2'b0, 2'b01, 3'b0, 9'h1F0});
    chk(stat_word[7:4] == 4'd3, "R6 link state block read", stat_word[7:4], 3);
    reg_write(2'd2, 11'h7C0);
    chk(stat_word[3], "R9 error on busy trigger", stat_word[3], 1);
    wait_idle();
    repeat (4) @(negedge clk);
    #1;
    chk(nreq == n0 + 1, "R9 busy trigger dropped", nreq, n0 + 1);
    chk(irq && stat_word[31:12] == 20'h1, "R12 R7 irq after block", stat_word, 32'h1008);
    reg_write(2'd0, 11'h7FF);
    chk(!irq && stat_word[3], "R11 error survives irq clear", stat_word, 32'h8);

    reg_write(2'd2, 11'h7C0);
    @(negedge clk); #1;
    chk(lk_req && lk_kind == 2'b00 && stat_word[7:4] == 4'd4, "R6 block write kind", lk_kind, 0);
    wait_idle();
    chk(stat_word[3] && irq, "R11 error still set", stat_word, 32'h1008);
    do_reset();
    chk(stat_word == 32'd0, "R11 reset clears error", stat_word, 0);

    // R9: trigger during direct word write
    lat = 5;
    win_write(11'h030, 32'h4444_4444, ns);
    n0 = nreq;
    reg_write(2'd1, 11'h7C0);
    chk(stat_word[3] && stat_word[11:8] == 4'd0, "R9 trigger during word write", stat_word, 32'h8);
    wait_idle();
    chk(nreq == n0, "R9 no block after word write", nreq, n0);
    do_reset();

    // R10: misaligned write still issued, misaligned trigger dropped
    lat = 1;
    win_write(11'h013, 32'h5555_5555, ns);
    chk(lk_req && lk_addr == 9'd4 && stat_word[3], "R10 misaligned write", lk_addr, 4);
    wait_idle();
    do_reset();
    n0 = nreq;
    reg_write(2'd1, 11'h7C2);
    repeat (5) @(negedge clk);
    #1;
    chk(nreq == n0 && stat_word[3] && !stat_word[0], "R10 misaligned trigger dropped", stat_word, 32'h8);
    do_reset();

    // Sweep over all word addresses: write then deferred read
    for (int a = 0; a < 512; a++) begin
      lat = a % 3;
      win_write(11'(a * 4), 32'hC000_0000 ^ 32'(a * 7), ns);
      chk(lk_req && lk_kind == 2'b10 && lk_addr == 9'(a) && lk_wdata == (32'hC000_0000 ^ 32'(a * 7)),
          "R2 sweep write", {23'd0, lk_addr}, a);
      win_read(11'(a * 4), d, ns, pend, k0);
      chk(d == fmod(9'(a)), "R5 sweep read", d, fmod(9'(a)));
      wait_idle();
    end
    chk(stat_word[31:13] == 0 && !stat_word[3], "R12 final status", stat_word, 32'h1000);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule